// File: doc/BRIEF.md
# Audio Channel Sample FIFO and Interrupt Controller

This block sits between the register bus of an audio serial port and its serializer. It holds one transmit and one receive sample FIFO, each with a programmable level threshold. It also truncates samples to a programmable resolution, detects overruns in both directions and produces a single maskable interrupt.

Software pushes transmit samples and pops receive samples through data registers. The serializer drains the transmit FIFO and fills the receive FIFO through valid/ready ports. Four raw status conditions can each raise the interrupt line: TX level low, RX data available, TX overrun and RX overrun. Only a register write changes the mask. The two overrun flags stay set until software reads the clear register for that direction.

Register word addresses are: 0 control, 1 TX threshold, 2 RX threshold, 3 resolution, 4 mask, 5 status (read only), 6 TX flush, 7 RX flush, 8 TX overrun clear, 9 RX overrun clear, 10 TX data (write), 11 RX data (read). A write takes effect at the clock edge on which `reg_wr_i` is sampled high. Read data is combinational from `reg_addr_i`. Side effects of a read (pop, flag clear) happen at the clock edge on which `reg_rd_i` is high.

Top module: `audio_fifo_irq`

## Requirements
- R1: After reset the registers read as follows: control reads 0, both threshold registers read DEPTH/2-1 (7), resolution reads 5, mask reads 0x33 and status reads 0x10. `irq_o`, `tx_out_valid_o` and `rx_in_ready_o` are low.
- R2: Control bit 0 enables TX. A write to TX data while TX is disabled is discarded. `tx_out_valid_o` is high only while TX is enabled and the TX FIFO is not empty. Samples leave in the order written, and one leaves on each cycle with valid and ready both high.
- R3: Control bit 1 enables RX. `rx_in_ready_o` equals that bit, and a sample offered while it is low is not stored. A read of RX data returns the oldest sample and removes it. A read of RX data while the FIFO is empty returns 0.
- R4: A threshold register holds P, which is the desired threshold minus one. Status bit 4 (TX low) is 1 while the TX level is at most P. Status bit 0 (RX available) is 1 while the RX level is greater than P.
- R5: A TX data write while TX is enabled and the TX FIFO is full sets status bit 5 (TX overrun). That sample is discarded, and the FIFO contents stay unchanged.
- R6: An RX sample offered while RX is enabled and the RX FIFO is full sets status bit 1 (RX overrun), and the sample is dropped. Fullness is judged at the start of the cycle, even if software pops in that same cycle.
- R7: Each overrun flag stays set until a read of its clear register: address 8 for TX, address 9 for RX. That read returns the flag in bit 0 and then clears it. If a new overrun happens in the cycle of the clear read, the flag stays set.
- R8: Writing a word with bit 0 set to address 6 empties the TX FIFO, and the same write to address 7 empties the RX FIFO. Writing a word with bit 0 clear to either address has no effect.
- R9: Samples entering either FIFO are truncated according to the resolution code in effect at entry. Code 2 keeps bits 15:0, code 4 keeps bits 23:0, and any other code keeps all 32 bits. The dropped upper bits read as zero.
- R10: `irq_o` is the OR of the status bits whose mask bit is 0. Mask bit positions match the status bits: bit 0 RX available, bit 1 RX overrun, bit 4 TX low, bit 5 TX overrun. The status register always shows the unmasked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (triggers pop/clear side effects) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data, combinational |
| irq_o | output | 1 | Combined interrupt |
| tx_out_valid_o | output | 1 | TX sample available to serializer |
| tx_out_ready_i | input | 1 | Serializer takes TX sample |
| tx_out_data_o | output | DW (32) | TX sample |
| rx_in_valid_i | input | 1 | Serializer offers an RX sample |
| rx_in_ready_o | output | 1 | RX side accepting samples |
| rx_in_data_i | input | DW (32) | RX sample |

## Verification
An RX overrun and a software read of the RX overrun clear register can fall in the same cycle. The bench first fills the receive FIFO and lets one extra sample set the flag. It then offers another sample from the serializer on the very cycle the clear register is read. The read must return 1, and the flag must still read 1 afterwards, because the new overrun outranks the clear. A second clear read must then return 1 and finally leave the flag at 0. The FIFO must hold exactly the first sixteen samples in order.

// File: rtl/afi_pkg.sv
package afi_pkg;

   localparam int unsigned REG_AW = 4;

   // register word addresses
   localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
   localparam logic [REG_AW-1:0] A_TXTHR   = 4'd1;
   localparam logic [REG_AW-1:0] A_RXTHR   = 4'd2;
   localparam logic [REG_AW-1:0] A_RES     = 4'd3;
   localparam logic [REG_AW-1:0] A_MASK    = 4'd4;
   localparam logic [REG_AW-1:0] A_STAT    = 4'd5;
   localparam logic [REG_AW-1:0] A_TXFLUSH = 4'd6;
   localparam logic [REG_AW-1:0] A_RXFLUSH = 4'd7;
   localparam logic [REG_AW-1:0] A_TXOCLR  = 4'd8;
   localparam logic [REG_AW-1:0] A_RXOCLR  = 4'd9;
   localparam logic [REG_AW-1:0] A_TXDATA  = 4'd10;
   localparam logic [REG_AW-1:0] A_RXDATA  = 4'd11;

   // status / mask bit positions
   localparam int unsigned ST_RXAV  = 0;
   localparam int unsigned ST_RXOVR = 1;
   localparam int unsigned ST_TXLOW = 4;
   localparam int unsigned ST_TXOVR = 5;

   localparam logic [5:0] MASK_RST = 6'h33;

   localparam logic [2:0] RES_16 = 3'd2;
   localparam logic [2:0] RES_24 = 3'd4;
   localparam logic [2:0] RES_32 = 3'd5;

   function automatic int unsigned res_bits(logic [2:0] code);
      case (code)
         RES_16:  return 16;
         RES_24:  return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/afi_fifo.sv
module afi_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     flush_i,
   input  logic                     push_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic                     pop_i,
   output logic [DW-1:0]            rdata_o,
   output logic [$clog2(DEPTH):0]   level_o,
   output logic                     full_o,
   output logic                     empty_o
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = AW + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "afi_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full_o  = (cnt_q == LW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign level_o = cnt_q;
   assign do_push = push_i & ~full_o & ~flush_i;
   assign do_pop  = pop_i & ~empty_o & ~flush_i;
   assign rdata_o = mem_q[rptr_q];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wptr_q] <= wdata_i;
   end

   p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LW'(DEPTH));

   p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> empty_o);

   p_full_push_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(wptr_q)));

endmodule

// File: rtl/afi_sticky.sv
module afi_sticky (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o <= 1'b0;
      else         flag_o <= set_i | (flag_o & ~clr_i);
   end

   p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o);

   p_hold_until_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/afi_resmask.sv
module afi_resmask
   import afi_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic [2:0]    code_i,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] dout_o
);
   int unsigned keep;
   assign keep = res_bits(code_i);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign dout_o[i] = din_i[i] & (i < keep);
   end
endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq
   import afi_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [3:0]        reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic              irq_o,
   output logic              tx_out_valid_o,
   input  logic              tx_out_ready_i,
   output logic [DW-1:0]     tx_out_data_o,
   input  logic              rx_in_valid_i,
   output logic              rx_in_ready_o,
   input  logic [DW-1:0]     rx_in_data_i
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = AW + 1;
   localparam logic [AW-1:0] THR_RST = AW'(DEPTH / 2 - 1);

   initial begin
      assert (DW >= 32 && DEPTH >= 4)
         else $fatal(1, "audio_fifo_irq: DW must be >= 32 and DEPTH >= 4");
   end

   logic          tx_en_q, rx_en_q;
   logic [AW-1:0] tx_thr_q, rx_thr_q;
   logic [2:0]    res_q;
   logic [5:0]    mask_q;

   // register writes
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_en_q  <= 1'b0;
         rx_en_q  <= 1'b0;
         tx_thr_q <= THR_RST;
         rx_thr_q <= THR_RST;
         res_q    <= RES_32;
         mask_q   <= MASK_RST;
      end else if (reg_wr_i) begin
         case (reg_addr_i)
            A_CTRL: begin
               tx_en_q <= reg_wdata_i[0];
               rx_en_q <= reg_wdata_i[1];
            end
            A_TXTHR: tx_thr_q <= reg_wdata_i[AW-1:0];
            A_RXTHR: rx_thr_q <= reg_wdata_i[AW-1:0];
            A_RES:   res_q    <= reg_wdata_i[2:0];
            A_MASK:  mask_q   <= reg_wdata_i[5:0];
            default: ;
         endcase
      end
   end

   // transmit path
   logic          tx_push, tx_pop, tx_flush, tx_full, tx_empty, tx_ovr;
   logic [DW-1:0] tx_in, tx_head;
   logic [LW-1:0] tx_level;

   assign tx_push  = reg_wr_i && (reg_addr_i == A_TXDATA) && tx_en_q;
   assign tx_flush = reg_wr_i && (reg_addr_i == A_TXFLUSH) && reg_wdata_i[0];
   assign tx_out_valid_o = tx_en_q & ~tx_empty;
   assign tx_pop   = tx_out_valid_o & tx_out_ready_i;
   assign tx_out_data_o = tx_out_valid_o ? tx_head : '0;

   afi_resmask #(.DW(DW)) u_tx_res (.code_i(res_q), .din_i(reg_wdata_i), .dout_o(tx_in));

   afi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
      .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .wdata_i(tx_in),
      .pop_i(tx_pop), .rdata_o(tx_head), .level_o(tx_level),
      .full_o(tx_full), .empty_o(tx_empty));

   afi_sticky u_tx_ovr (
      .clk_i, .rst_ni, .set_i(tx_push & tx_full),
      .clr_i(reg_rd_i && (reg_addr_i == A_TXOCLR)), .flag_o(tx_ovr));

   // receive path
   logic          rx_push, rx_pop, rx_flush, rx_full, rx_empty, rx_ovr;
   logic [DW-1:0] rx_in, rx_head;
   logic [LW-1:0] rx_level;

   assign rx_in_ready_o = rx_en_q;
   assign rx_push  = rx_in_valid_i & rx_en_q;
   assign rx_flush = reg_wr_i && (reg_addr_i == A_RXFLUSH) && reg_wdata_i[0];
   assign rx_pop   = reg_rd_i && (reg_addr_i == A_RXDATA);

   afi_resmask #(.DW(DW)) u_rx_res (.code_i(res_q), .din_i(rx_in_data_i), .dout_o(rx_in));

   afi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
      .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push), .wdata_i(rx_in),
      .pop_i(rx_pop), .rdata_o(rx_head), .level_o(rx_level),
      .full_o(rx_full), .empty_o(rx_empty));

   afi_sticky u_rx_ovr (
      .clk_i, .rst_ni, .set_i(rx_push & rx_full),
      .clr_i(reg_rd_i && (reg_addr_i == A_RXOCLR)), .flag_o(rx_ovr));

   // status and interrupt
   logic [5:0] status;
   always_comb begin
      status = '0;
      status[ST_RXAV]  = rx_level > {1'b0, rx_thr_q};
      status[ST_RXOVR] = rx_ovr;
      status[ST_TXLOW] = tx_level <= {1'b0, tx_thr_q};
      status[ST_TXOVR] = tx_ovr;
   end

   assign irq_o = |(status & ~mask_q);

   // register reads
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_CTRL:   reg_rdata_o[1:0]    = {rx_en_q, tx_en_q};
         A_TXTHR:  reg_rdata_o[AW-1:0] = tx_thr_q;
         A_RXTHR:  reg_rdata_o[AW-1:0] = rx_thr_q;
         A_RES:    reg_rdata_o[2:0]    = res_q;
         A_MASK:   reg_rdata_o[5:0]    = mask_q;
         A_STAT:   reg_rdata_o[5:0]    = status;
         A_TXOCLR: reg_rdata_o[0]      = tx_ovr;
         A_RXOCLR: reg_rdata_o[0]      = rx_ovr;
         A_RXDATA: reg_rdata_o         = rx_empty ? '0 : rx_head;
         default:  ;
      endcase
   end

   p_tx_valid_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_out_valid_o |-> tx_en_q);

   p_irq_all_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[5:4] == 2'b11 && mask_q[1:0] == 2'b11) |-> !irq_o);

   p_txovr_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_ovr) |-> $past(reg_wr_i && reg_addr_i == A_TXDATA));

   p_rxovr_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_ovr) |-> $past(rx_in_valid_i && rx_en_q));

endmodule

// File: tb/audio_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_irq_tb_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq;
   logic          tx_valid, tx_ready = 1'b0;
   logic [DW-1:0] tx_data;
   logic          rx_valid = 1'b0, rx_ready;
   logic [DW-1:0] rx_data = '0;

   int n_vec = 0, n_bad = 0;

   always #10 clk = ~clk;

   audio_fifo_irq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
      .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .irq_o(irq), .tx_out_valid_o(tx_valid), .tx_out_ready_i(tx_ready),
      .tx_out_data_o(tx_data), .rx_in_valid_i(rx_valid), .rx_in_ready_o(rx_ready),
      .rx_in_data_i(rx_data));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic stat_bit(int b, logic exp, string req);
      logic [31:0] d;
      rd(4'd5, d);
      chk(req, 32'(d[b]), 32'(exp));
   endtask

   task automatic txpop(output logic v, output logic [31:0] d);
      @(negedge clk);
      tx_ready = 1'b1;
      #1 v = tx_valid; d = tx_data;
      @(posedge clk); #1;
      tx_ready = 1'b0;
   endtask

   task automatic rxput(logic [31:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic irq_is(logic exp, string req);
      @(negedge clk); #1;
      chk(req, 32'(irq), 32'(exp));
   endtask

   task automatic t_reset;
      logic [31:0] d;
      @(negedge clk); #1;
      chk("R1 irq", 32'(irq), 0);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 rx_ready", 32'(rx_ready), 0);
      rd(4'd0, d); chk("R1 ctrl", d, 0);
      rd(4'd1, d); chk("R1 txthr", d, 7);
      rd(4'd2, d); chk("R1 rxthr", d, 7);
      rd(4'd3, d); chk("R1 res", d, 5);
      rd(4'd4, d); chk("R1 mask", d, 32'h33);
      rd(4'd5, d); chk("R1 status", d, 32'h10);
   endtask

   task automatic t_tx_path;
      logic v; logic [31:0] d;
      wr(4'd10, 32'h11111111);      // TX disabled: dropped (R2)
      wr(4'd0, 32'h1);
      txpop(v, d); chk("R2 disabled write dropped", 32'(v), 0);
      wr(4'd3, 32'd2); wr(4'd10, 32'hDEADBEEF);
      wr(4'd3, 32'd4); wr(4'd10, 32'h12345678);
      wr(4'd3, 32'd5); wr(4'd10, 32'hCAFEF00D);
      wr(4'd3, 32'd7); wr(4'd10, 32'hFFFFFFFF);
      wr(4'd3, 32'd5);
      txpop(v, d); chk("R9 res16 valid", 32'(v), 1); chk("R9 res16", d, 32'h0000BEEF);
      txpop(v, d); chk("R9 res24", d, 32'h00345678);
      txpop(v, d); chk("R2 order res32", d, 32'hCAFEF00D);
      txpop(v, d); chk("R9 other code full", d, 32'hFFFFFFFF);
      txpop(v, d); chk("R2 empty no valid", 32'(v), 0);
   endtask

   task automatic t_threshold;
      logic v; logic [31:0] d;
      wr(4'd1, 32'd2);
      wr(4'd10, 32'h1); wr(4'd10, 32'h2);
      stat_bit(4, 1'b1, "R4 tx level 2 <= P 2");
      wr(4'd10, 32'h3);
      stat_bit(4, 1'b0, "R4 tx level 3 > P 2");
      wr(4'd6, 32'h0);
      stat_bit(4, 1'b0, "R8 flush write 0 no effect");
      wr(4'd6, 32'h1);
      stat_bit(4, 1'b1, "R8 tx flush empties");
      txpop(v, d); chk("R8 tx empty after flush", 32'(v), 0);
      wr(4'd0, 32'h3);
      wr(4'd2, 32'd1);
      rxput(32'hA);
      stat_bit(0, 1'b0, "R4 rx level 1 not > P 1");
      rxput(32'hB);
      stat_bit(0, 1'b1, "R4 rx level 2 > P 1");
      rd(4'd11, d); chk("R3 rx oldest", d, 32'hA);
      stat_bit(0, 1'b0, "R4 rx level back to 1");
      rd(4'd11, d); chk("R3 rx second", d, 32'hB);
      rd(4'd11, d); chk("R3 empty read zero", d, 0);
      rxput(32'hC);
      wr(4'd7, 32'h1);
      rd(4'd11, d); chk("R8 rx flush empties", d, 0);
   endtask

   task automatic t_tx_overrun;
      logic v; logic [31:0] d;
      wr(4'd1, 32'd7);
      for (int i = 0; i < 16; i++) wr(4'd10, 32'h100 + i);
      stat_bit(5, 1'b0, "R5 full no overrun yet");
      wr(4'd10, 32'hBAD);
      stat_bit(5, 1'b1, "R5 write to full sets overrun");
      stat_bit(5, 1'b1, "R7 status read keeps flag");
      rd(4'd8, d); chk("R7 tx clear read returns flag", d, 1);
      stat_bit(5, 1'b0, "R7 tx flag cleared");
      rd(4'd8, d); chk("R7 tx clear read again", d, 0);
      for (int i = 0; i < 16; i++) begin
         txpop(v, d); chk("R5 tx contents kept", d, 32'h100 + i);
      end
      txpop(v, d); chk("R5 overrun sample discarded", 32'(v), 0);
   endtask

   task automatic t_rx_overrun_concurrent;
      logic [31:0] d;
      for (int i = 0; i < 16; i++) rxput(32'h200 + i);
      stat_bit(1, 1'b0, "R6 full no overrun yet");
      rxput(32'hBAD1);
      stat_bit(1, 1'b1, "R6 delivery to full sets overrun");
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 32'hBAD2; reg_rd = 1'b1; reg_addr = 4'd9;
      #1 chk("R7 rx clear read returns flag", reg_rdata, 1);
      @(posedge clk); #1;
      rx_valid = 1'b0; reg_rd = 1'b0;
      stat_bit(1, 1'b1, "R7 set wins over clear");
      rd(4'd9, d); chk("R7 rx clear read", d, 1);
      stat_bit(1, 1'b0, "R7 rx flag cleared");
      for (int i = 0; i < 16; i++) begin
         rd(4'd11, d); chk("R6 rx contents kept", d, 32'h200 + i);
      end
      rd(4'd11, d); chk("R6 dropped samples absent", d, 0);
      wr(4'd0, 32'h1);
      @(negedge clk); #1 chk("R3 rx_ready low when disabled", 32'(rx_ready), 0);
      rxput(32'h77);
      rd(4'd11, d); chk("R3 disabled sample not stored", d, 0);
   endtask

   task automatic t_irq;
      irq_is(1'b0, "R10 all masked");
      stat_bit(4, 1'b1, "R10 raw tx low visible");
      wr(4'd4, 32'h23);
      irq_is(1'b1, "R10 tx low unmasked");
      wr(4'd1, 32'd0);
      wr(4'd10, 32'h5);
      irq_is(1'b0, "R10 tx above threshold");
      wr(4'd0, 32'h3);
      wr(4'd2, 32'd0);
      wr(4'd4, 32'h32);
      irq_is(1'b0, "R10 rx empty");
      rxput(32'h9);
      irq_is(1'b1, "R10 rx available raises irq");
      wr(4'd4, 32'h33);
      irq_is(1'b0, "R10 masked again");
      stat_bit(0, 1'b1, "R10 status stays raw");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_tx_path();
      t_threshold();
      t_tx_overrun();
      t_rx_overrun_concurrent();
      t_irq();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule